// File: doc/BRIEF.md
# Slice-Shared Ingress Policer

This block meters ingress packets for a link aggregate whose member links are spread over several slices. Each slice owns one pair of token buckets, a committed one and a peak one. Every member link on that slice draws from the same pair. There is no bucket for each member. The refill rate of a slice is a programmed percentage of the summed speed of the members that are present on that slice. Adding or removing a member therefore changes the rate of its slice at once.

Each cycle the block can accept one packet, given as a length, a member index and a valid strobe. One cycle later it returns a colour verdict and a drop flag, and the drop flag is raised for red. Two metering modes are available: a single-rate two-colour meter and a dual-rate three-colour meter. Excess traffic is dropped, not delayed.

Top module: `slice_policer`

## Requirements
- R1: With `mode_i` = 0 (single rate), a packet is green when the committed fill of its slice is at least its cost, and red otherwise. Yellow never appears.
- R2: With `mode_i` = 1 (dual rate), a packet is red if the peak fill is below its cost. Otherwise it is yellow if the committed fill is below its cost. Otherwise it is green.
- R3: The verdict for a packet presented in cycle t appears in cycle t+1 with `verdict_valid_o` high. The encoding is 0 green, 1 yellow, 2 red. `drop_o` is high exactly for red verdicts, and `verdict_valid_o` is low in cycles that follow no packet.
- R4: The refill per cycle of a slice, in hundredths of a byte, equals the percentage multiplied by the summed `member_speed_i` (bytes per cycle) of the present members mapped to that slice. A packet costs its length multiplied by 100.
- R5: Members on the same slice share one committed/peak bucket pair. Traffic on one member lowers the fill seen by the others, and a lone flow may use the whole slice rate.
- R6: At every clock edge a bucket becomes min(burst × 100, fill − debit + refill). The burst is `cbs_i` for the committed bucket and `pbs_i` for the peak bucket.
- R7: A green packet debits the committed bucket, and in dual-rate mode the peak bucket as well. A yellow packet debits only the peak bucket. A red packet debits nothing.
- R8: A packet only affects the buckets of its own slice. Each slice is capped by its own rate even when another slice is idle.
- R9: A packet on a member whose `member_present_i` bit is low is red and debits no bucket.
- R10: Changing membership, speeds or percentages changes only future refill. The current fills are kept.
- R11: After reset all fills are zero and no verdict is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 single-rate two-colour, 1 dual-rate three-colour |
| member_present_i | input | NUM_MEMBERS | Member link is part of the aggregate |
| member_slice_i | input | NUM_MEMBERS*SLICE_W | Slice index of each member |
| member_speed_i | input | NUM_MEMBERS*SPD_W | Speed of each member, bytes per cycle |
| cir_pct_i | input | PCT_W | Committed rate percentage |
| pir_pct_i | input | PCT_W | Peak rate percentage |
| cbs_i | input | BURST_W | Committed burst, bytes |
| pbs_i | input | BURST_W | Peak burst, bytes |
| pkt_valid_i | input | 1 | Packet strobe |
| pkt_len_i | input | LEN_W | Packet length, bytes |
| pkt_member_i | input | MEM_W | Member link of the packet |
| verdict_valid_o | output | 1 | Verdict strobe |
| verdict_o | output | 2 | Colour verdict |
| drop_o | output | 1 | Packet must be dropped |

## Verification
A wrong fill, refill rate or debit leaves no mark at the ports until a later packet on the same slice tests its cost against that fill. The verdict of that packet then differs from the bench model, typically within a few packets while the slice is congested. A slice mapping error shows up as a colour taken from the wrong slice, and is exposed by flooding one slice while another sits at full burst. Fill loss on a membership change shows up on the first large packet after the change.

// File: rtl/slice_pol_pkg.sv
package slice_pol_pkg;
  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } colour_e;

  // token unit: hundredths of a byte
  localparam int unsigned TOK_SCALE = 100;
endpackage

// File: rtl/slice_pol_rate.sv
module slice_pol_rate #(
  parameter int NUM_MEMBERS = 4,
  parameter int SLICE_W     = 1,
  parameter int SPD_W       = 8,
  parameter int PCT_W       = 7,
  parameter int BKT_W       = 32,
  parameter int SLICE_ID    = 0
) (
  input  logic [NUM_MEMBERS-1:0]         member_present_i,
  input  logic [NUM_MEMBERS*SLICE_W-1:0] member_slice_i,
  input  logic [NUM_MEMBERS*SPD_W-1:0]   member_speed_i,
  input  logic [PCT_W-1:0]               cir_pct_i,
  input  logic [PCT_W-1:0]               pir_pct_i,
  output logic [BKT_W-1:0]               cir_rate_o,
  output logic [BKT_W-1:0]               pir_rate_o
);
  logic [BKT_W-1:0] speed_sum;

  always_comb begin
    speed_sum = '0;
    for (int m = 0; m < NUM_MEMBERS; m++) begin
      if (member_present_i[m] &&
          member_slice_i[m*SLICE_W +: SLICE_W] == SLICE_W'(SLICE_ID))
        speed_sum = speed_sum + BKT_W'(member_speed_i[m*SPD_W +: SPD_W]);
    end
  end

  assign cir_rate_o = speed_sum * BKT_W'(cir_pct_i);
  assign pir_rate_o = speed_sum * BKT_W'(pir_pct_i);
endmodule

// File: rtl/slice_pol_bucket.sv
module slice_pol_bucket #(
  parameter int BKT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BKT_W-1:0] rate_i,
  input  logic [BKT_W-1:0] cap_i,
  input  logic             debit_i,
  input  logic [BKT_W-1:0] cost_i,
  output logic [BKT_W-1:0] fill_o
);
  logic [BKT_W-1:0] fill_q, fill_d;
  logic [BKT_W:0]   after;

  always_comb begin
    after = {1'b0, fill_q} - (debit_i ? {1'b0, cost_i} : '0) + {1'b0, rate_i};
    if (after > {1'b0, cap_i}) fill_d = cap_i;
    else                       fill_d = after[BKT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= fill_d;
  end

  assign fill_o = fill_q;

  // meter must never debit more than the bucket holds
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debit_i |-> fill_q >= cost_i);

  assert_fill_capped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fill_q <= $past(cap_i));
endmodule

// File: rtl/slice_pol_meter.sv
module slice_pol_meter
  import slice_pol_pkg::*;
#(
  parameter int BKT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             two_rate_i,
  input  logic             hit_i,
  input  logic [BKT_W-1:0] cost_i,
  input  logic [BKT_W-1:0] cir_rate_i,
  input  logic [BKT_W-1:0] pir_rate_i,
  input  logic [BKT_W-1:0] c_cap_i,
  input  logic [BKT_W-1:0] p_cap_i,
  output colour_e          colour_o
);
  logic [BKT_W-1:0] c_fill, p_fill;
  logic             c_ok, p_ok, c_debit, p_debit;

  assign c_ok = c_fill >= cost_i;
  assign p_ok = p_fill >= cost_i;

  always_comb begin
    if (two_rate_i) begin
      if (!p_ok)      colour_o = COL_RED;
      else if (!c_ok) colour_o = COL_YELLOW;
      else            colour_o = COL_GREEN;
    end else begin
      colour_o = c_ok ? COL_GREEN : COL_RED;
    end
  end

  assign c_debit = hit_i && (colour_o == COL_GREEN);
  assign p_debit = hit_i && two_rate_i && (colour_o != COL_RED);

  slice_pol_bucket #(.BKT_W(BKT_W)) u_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (cir_rate_i),
    .cap_i   (c_cap_i),
    .debit_i (c_debit),
    .cost_i  (cost_i),
    .fill_o  (c_fill)
  );

  slice_pol_bucket #(.BKT_W(BKT_W)) u_peak (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (pir_rate_i),
    .cap_i   (p_cap_i),
    .debit_i (p_debit),
    .cost_i  (cost_i),
    .fill_o  (p_fill)
  );
endmodule

// File: rtl/slice_policer.sv
module slice_policer
  import slice_pol_pkg::*;
#(
  parameter int NUM_MEMBERS = 4,
  parameter int NUM_SLICES  = 2,
  parameter int SPD_W       = 8,
  parameter int PCT_W       = 7,
  parameter int BURST_W     = 16,
  parameter int LEN_W       = 14,
  parameter int BKT_W       = 32,
  localparam int SLICE_W    = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int MEM_W      = (NUM_MEMBERS > 1) ? $clog2(NUM_MEMBERS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           mode_i,
  input  logic [NUM_MEMBERS-1:0]         member_present_i,
  input  logic [NUM_MEMBERS*SLICE_W-1:0] member_slice_i,
  input  logic [NUM_MEMBERS*SPD_W-1:0]   member_speed_i,
  input  logic [PCT_W-1:0]               cir_pct_i,
  input  logic [PCT_W-1:0]               pir_pct_i,
  input  logic [BURST_W-1:0]             cbs_i,
  input  logic [BURST_W-1:0]             pbs_i,
  input  logic                           pkt_valid_i,
  input  logic [LEN_W-1:0]               pkt_len_i,
  input  logic [MEM_W-1:0]               pkt_member_i,
  output logic                           verdict_valid_o,
  output logic [1:0]                     verdict_o,
  output logic                           drop_o
);
  logic [BKT_W-1:0]      cost, c_cap, p_cap;
  logic [SLICE_W-1:0]    pkt_slice;
  logic                  pkt_present;
  logic [NUM_SLICES-1:0] hit;
  colour_e               slice_colour [NUM_SLICES];
  colour_e               colour;

  assign cost        = BKT_W'(pkt_len_i) * BKT_W'(TOK_SCALE);
  assign c_cap       = BKT_W'(cbs_i) * BKT_W'(TOK_SCALE);
  assign p_cap       = BKT_W'(pbs_i) * BKT_W'(TOK_SCALE);
  assign pkt_slice   = member_slice_i[pkt_member_i*SLICE_W +: SLICE_W];
  assign pkt_present = member_present_i[pkt_member_i];

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [BKT_W-1:0] cir_rate, pir_rate;

    assign hit[s] = pkt_valid_i && pkt_present && (pkt_slice == SLICE_W'(s));

    slice_pol_rate #(
      .NUM_MEMBERS (NUM_MEMBERS),
      .SLICE_W     (SLICE_W),
      .SPD_W       (SPD_W),
      .PCT_W       (PCT_W),
      .BKT_W       (BKT_W),
      .SLICE_ID    (s)
    ) u_rate (
      .member_present_i (member_present_i),
      .member_slice_i   (member_slice_i),
      .member_speed_i   (member_speed_i),
      .cir_pct_i        (cir_pct_i),
      .pir_pct_i        (pir_pct_i),
      .cir_rate_o       (cir_rate),
      .pir_rate_o       (pir_rate)
    );

    slice_pol_meter #(.BKT_W(BKT_W)) u_meter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .two_rate_i (mode_i),
      .hit_i      (hit[s]),
      .cost_i     (cost),
      .cir_rate_i (cir_rate),
      .pir_rate_i (pir_rate),
      .c_cap_i    (c_cap),
      .p_cap_i    (p_cap),
      .colour_o   (slice_colour[s])
    );
  end

  always_comb begin
    colour = COL_RED;
    for (int s = 0; s < NUM_SLICES; s++)
      if (pkt_present && pkt_slice == SLICE_W'(s)) colour = slice_colour[s];
  end

  logic       valid_q, drop_q;
  logic [1:0] verdict_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      verdict_q <= COL_RED;
      drop_q    <= 1'b0;
    end else begin
      valid_q   <= pkt_valid_i;
      verdict_q <= colour;
      drop_q    <= pkt_valid_i && (colour == COL_RED);
    end
  end

  assign verdict_valid_o = valid_q;
  assign verdict_o       = verdict_q;
  assign drop_o          = drop_q;

  assert_one_slice_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  assert_absent_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_present) |-> (hit == '0));

  assert_no_yellow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !mode_i) |=> (verdict_o != COL_YELLOW));

  assert_drop_red_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> (verdict_valid_o && (drop_o == (verdict_o == COL_RED))));
endmodule

// File: tb/slice_policer_bench.sv
module slice_policer_bench;
  localparam int NM = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode;
  logic [3:0]  present;
  logic [3:0]  slc;
  logic [31:0] spd;
  logic [6:0]  cir_pct, pir_pct;
  logic [15:0] cbs, pbs;
  logic        pkt_v;
  logic [13:0] pkt_len;
  logic [1:0]  pkt_mem;
  logic        v_o, drop_o;
  logic [1:0]  verdict_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  slice_policer u_slice_policer (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .mode_i           (mode),
    .member_present_i (present),
    .member_slice_i   (slc),
    .member_speed_i   (spd),
    .cir_pct_i        (cir_pct),
    .pir_pct_i        (pir_pct),
    .cbs_i            (cbs),
    .pbs_i            (pbs),
    .pkt_valid_i      (pkt_v),
    .pkt_len_i        (pkt_len),
    .pkt_member_i     (pkt_mem),
    .verdict_valid_o  (v_o),
    .verdict_o        (verdict_o),
    .drop_o           (drop_o)
  );

  longint cfill [2];
  longint pfill [2];
  bit     pend;
  int     pend_col;
  string  pend_tag;

  function automatic longint slice_rate(int s, int pct);
    longint sum = 0;
    for (int m = 0; m < NM; m++)
      if (present[m] && int'(slc[m]) == s) sum += longint'(spd[m*8 +: 8]);
    return sum * pct;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of one clock edge with the inputs now on the pins
  task automatic model_step();
    longint cost, rc, rp, nc, np;
    int     s, col;
    bit     dc, dp;
    cost = longint'(pkt_len) * 100;
    col = 2;
    s = int'(slc[pkt_mem]);
    dc = 0;
    dp = 0;
    if (present[pkt_mem]) begin
      if (mode) begin
        if (pfill[s] < cost)      col = 2;
        else if (cfill[s] < cost) col = 1;
        else                      col = 0;
      end else begin
        col = (cfill[s] >= cost) ? 0 : 2;
      end
      dc = pkt_v && col == 0;
      dp = pkt_v && mode && col != 2;
    end
    for (int k = 0; k < 2; k++) begin
      rc = slice_rate(k, int'(cir_pct));
      rp = slice_rate(k, int'(pir_pct));
      nc = cfill[k] - ((dc && k == s) ? cost : 0) + rc;
      np = pfill[k] - ((dp && k == s) ? cost : 0) + rp;
      cfill[k] = (nc > longint'(cbs) * 100) ? longint'(cbs) * 100 : nc;
      pfill[k] = (np > longint'(pbs) * 100) ? longint'(pbs) * 100 : np;
    end
    pend     = pkt_v;
    pend_col = col;
  endtask

  task automatic cyc(bit v, int mem, int len, string tag);
    if (pend) begin
      chk(v_o === 1'b1 && int'(verdict_o) == pend_col, pend_tag, int'(verdict_o), pend_col);
      chk(drop_o === (pend_col == 2), "R3 drop", int'(drop_o), int'(pend_col == 2));
    end else begin
      chk(v_o === 1'b0 && drop_o === 1'b0, "R3 idle", int'(v_o), 0);
    end
    pkt_v    = v;
    pkt_mem  = 2'(mem);
    pkt_len  = 14'(len);
    pend_tag = tag;
    model_step();
    @(negedge clk);
  endtask

  task automatic rnd_run(int cycles, int prob, int mask, string tag);
    for (int i = 0; i < cycles; i++) begin
      int m;
      do m = int'($urandom % 4); while (!mask[m]);
      cyc(($urandom % prob) == 0, m, 64 + int'($urandom % 1437), tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mode = 1'b1;
    present = 4'b0111;
    slc = 4'b1100;
    spd = {8'd10, 8'd10, 8'd10, 8'd10};
    cir_pct = 7'd50;
    pir_pct = 7'd80;
    cbs = 16'd3000;
    pbs = 16'd6000;
    pkt_v = 1'b0;
    pkt_len = '0;
    pkt_mem = '0;
    cfill[0] = 0; cfill[1] = 0; pfill[0] = 0; pfill[1] = 0;
    pend = 0;
    pend_col = 0;
    pend_tag = "";
    repeat (3) @(negedge clk);
    chk(v_o === 1'b0 && drop_o === 1'b0, "R11 reset", int'(v_o), 0);
    rst_n = 1'b1;
    // first packet right after reset meets empty buckets
    cyc(1, 0, 64, "R11 empty fill");
    for (int i = 0; i < 800; i++) cyc(0, 0, 64, "R6 idle refill");
    // full committed burst is available after filling
    cyc(1, 0, 3000, "R6 full burst");
    cyc(1, 1, 100, "R5 shared drained");
    rnd_run(1500, 30, 4'b0011, "R5 shared slice");
    rnd_run(800, 30, 4'b0001, "R5 lone flow");
    for (int i = 0; i < 400; i++) cyc(0, 0, 64, "R8 idle");
    rnd_run(600, 4, 4'b0100, "R8 flood slice1");
    cyc(1, 0, 3000, "R8 other slice untouched");
    cyc(1, 3, 64, "R9 absent member");
    rnd_run(300, 10, 4'b1111, "R9 mixed absent");
    present = 4'b1111;
    pir_pct = 7'd100;
    rnd_run(800, 20, 4'b1111, "R10 membership change");
    for (int i = 0; i < 700; i++) cyc(0, 0, 64, "R10 idle");
    present = 4'b0011;
    cyc(1, 1, 3000, "R10 fill kept");
    present = 4'b1111;
    spd = {8'd10, 8'd5, 8'd30, 8'd25};
    rnd_run(1000, 25, 4'b1111, "R4 uneven speeds");
    mode = 1'b0;
    rnd_run(1200, 25, 4'b1111, "R1 single rate");
    mode = 1'b1;
    cbs = 16'd1500;
    rnd_run(1200, 15, 4'b1111, "R2 R7 dual rate");
    cyc(0, 0, 64, "R3 flush");
    cyc(0, 0, 64, "R3 flush");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule